// File: doc/BRIEF.md
# NAND Page Marker Swap Unit

This block sits in the byte path between a NAND flash port and a controller's page buffer. A large page holds 2048 data bytes and 64 spare bytes. The controller moves it as four pieces, each made of 512 data bytes followed by 16 spare bytes. In that interleaved stream the factory bad-block marker arrives at stream position 2048, which the buffer treats as data. The unit counts bytes from a page-start pulse and exchanges the byte at position 2048 with the byte at position 2101, which is spare byte 5 of the last piece. After the exchange the marker lands in the logical spare area and that data byte sits in the marker slot. The exchange is its own inverse, so one instance serves both reads and programs.

Position 2048 arrives before position 2101. The unit therefore holds the bytes in between in a small ring buffer and emits them in exchanged order. Both sides use valid/ready byte streams with full backpressure. The exchange happens only when the page is large and the interleaved mode is selected. Both settings are sampled at the page-start pulse.

On the first page of a block the unit also looks at the byte that arrives at position 2048. If that byte is anything other than 0xFF, it raises a sticky bad-block flag. The flag holds until the next first-page start.

Top module: `nand_marker_swap`

## Requirements
- R1: After reset, out_valid, page_end and bad_block are 0 and in_ready is 1.
- R2: When the exchange is active, output position 2048 (counted from 0 after page_start) carries input byte 2101, output position 2101 carries input byte 2048, and every other position carries its own input byte.
- R3: When cfg_interleave or cfg_large_page is 0 at page_start, all 2112 output bytes equal the input bytes in order.
- R4: cfg_interleave and cfg_large_page are sampled only on the page_start cycle. Changing them during a page does not change that page's output.
- R5: A page passed through the unit twice with the exchange active comes out equal to the original page.
- R6: With random stalls on both sides, each of the 2112 input bytes appears at the output exactly once, in the order that R2 or R3 defines.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change on the next cycle.
- R8: page_end is high for exactly one cycle, in the cycle right after output byte 2111 is accepted.
- R9: On a page started with first_page=1, bad_block becomes 1 if input byte 2048 is not 0xFF and becomes 0 if it is 0xFF. It shows the new value from the cycle after that byte is accepted.
- R10: A page started with first_page=0 leaves bad_block unchanged, whatever its byte 2048 holds.
- R11: While out_ready stays 1, in_ready never drops, including during the exchange window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_interleave | input | 1 | Interleaved four-piece layout selected |
| cfg_large_page | input | 1 | Page is larger than 512 bytes |
| page_start | input | 1 | One-cycle pulse before the first byte of a page |
| first_page | input | 1 | Page being started is page 0 of its block |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Unit can accept an input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| page_end | output | 1 | One-cycle pulse after the last byte of a page is accepted |
| bad_block | output | 1 | Sticky factory-bad flag for the current block |

## Verification
An accepted input byte reaches out_valid two cycles later. The exception is output position 2048, which waits until the cycle after input byte 2101 is accepted. Because the bench compares whole pages collected at handshakes, its data checks hold under any stall pattern. bad_block is checked after the page has drained, which is well past its one-cycle update. page_end is sampled at the falling edge right after the handshake of byte 2111, and the number of high cycles per page is counted to confirm a single pulse. R11 is checked only in runs where the downstream side never stalls.

// File: rtl/nand_swap_pkg.sv
package nand_swap_pkg;
  localparam int          BYTE_W = 8;
  localparam logic [7:0]  ERASED = 8'hFF;
endpackage

// File: rtl/msu_pos_counter.sv
module msu_pos_counter #(
  parameter int LIMIT = 2112,
  parameter int W     = $clog2(LIMIT)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] pos,
  output logic         at_last
);
  assign at_last = (pos == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)   pos <= '0;
    else if (inc)     pos <= at_last ? '0 : pos + 1'b1;
  end
endmodule

// File: rtl/msu_byte_fifo.sv
module msu_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/msu_bad_flag.sv
module msu_bad_flag
  import nand_swap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_set,
  input  logic              disarm,
  input  logic              cap,
  input  logic [BYTE_W-1:0] din,
  output logic              bad
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      bad   <= 1'b0;
      armed <= 1'b0;
    end else if (arm_set) begin
      bad   <= 1'b0;
      armed <= 1'b1;
    end else if (disarm) begin
      armed <= 1'b0;
    end else if (cap && armed) begin
      bad   <= (din != ERASED);
      armed <= 1'b0;
    end
  end

  // R10
  bad_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!arm_set && !(cap && armed)) |=> $stable(bad));
  // R9
  bad_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!arm_set && !disarm && cap && armed && din != ERASED) |=> bad);
endmodule

// File: rtl/nand_marker_swap.sv
module nand_marker_swap
  import nand_swap_pkg::*;
#(
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int MARK_POS    = 2048,
  parameter int PAIR_POS    = 2101,
  parameter int FIFO_DEPTH  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_interleave,
  input  logic       cfg_large_page,
  input  logic       page_start,
  input  logic       first_page,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       page_end,
  output logic       bad_block
);
  localparam int PAGE_BYTES = DATA_BYTES + SPARE_BYTES;
  localparam int POS_W      = $clog2(PAGE_BYTES);

  logic              swap_q;
  logic              in_fire, load;
  logic [POS_W-1:0]  in_pos, out_pos;
  logic              in_last_unused, out_at_last;
  logic              fifo_empty, fifo_full;
  logic [BYTE_W-1:0] fifo_dout;
  logic [BYTE_W-1:0] reg_a, reg_b;
  logic              b_seen, out_last;
  logic              at_mark_out, at_pair_out, wait_pair;

  assign in_ready = !fifo_full;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)             swap_q <= 1'b0;
    else if (page_start) swap_q <= cfg_interleave && cfg_large_page;
  end

  msu_pos_counter #(.LIMIT(PAGE_BYTES), .W(POS_W)) u_in_cnt (
    .clk(clk), .rst(rst), .clr(page_start), .inc(in_fire),
    .pos(in_pos), .at_last(in_last_unused));

  msu_pos_counter #(.LIMIT(PAGE_BYTES), .W(POS_W)) u_out_cnt (
    .clk(clk), .rst(rst), .clr(page_start), .inc(load),
    .pos(out_pos), .at_last(out_at_last));

  msu_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
    .clk(clk), .rst(rst), .clr(page_start), .push(in_fire), .din(in_data),
    .pop(load), .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full));

  msu_bad_flag u_flag (
    .clk(clk), .rst(rst),
    .arm_set(page_start && first_page),
    .disarm(page_start && !first_page),
    .cap(in_fire && in_pos == POS_W'(MARK_POS)),
    .din(in_data), .bad(bad_block));

  // capture both ends of the exchanged pair as they stream in
  always_ff @(posedge clk) begin
    if (rst || page_start) begin
      b_seen <= 1'b0;
    end else begin
      if (in_fire && in_pos == POS_W'(PAIR_POS)) b_seen <= 1'b1;
      else if (load && at_mark_out)              b_seen <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire && in_pos == POS_W'(MARK_POS)) reg_a <= in_data;
    if (in_fire && in_pos == POS_W'(PAIR_POS)) reg_b <= in_data;
  end

  assign at_mark_out = swap_q && (out_pos == POS_W'(MARK_POS));
  assign at_pair_out = swap_q && (out_pos == POS_W'(PAIR_POS));
  assign wait_pair   = at_mark_out && !b_seen;
  assign load        = !fifo_empty && (!out_valid || out_ready) && !wait_pair;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      page_end  <= 1'b0;
    end else begin
      page_end <= out_valid && out_ready && out_last;
      if (load) begin
        out_valid <= 1'b1;
        out_last  <= out_at_last;
        out_data  <= at_mark_out ? reg_b : (at_pair_out ? reg_a : fifo_dout);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R8
  page_end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    page_end |=> !page_end);
  // R2
  pair_order_chk: assert property (@(posedge clk) disable iff (rst)
    (in_fire && swap_q && in_pos == POS_W'(PAIR_POS)) |-> !(out_valid && out_pos > POS_W'(MARK_POS) && out_pos <= POS_W'(PAIR_POS) && !b_seen && out_pos == POS_W'(PAIR_POS)));
endmodule

// File: tb/nand_marker_swap_bench.sv
module nand_marker_swap_bench;
  localparam int PAGE = 2112;
  localparam int MARK = 2048;
  localparam int PAIR = 2101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_interleave = 1'b0, cfg_large_page = 1'b0;
  logic page_start = 1'b0, first_page = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic out_valid, out_ready = 1'b0;
  logic [7:0] out_data;
  logic page_end, bad_block;

  always #4 clk = ~clk;

  nand_marker_swap u_nand_marker_swap (
    .clk(clk), .rst(rst), .cfg_interleave(cfg_interleave),
    .cfg_large_page(cfg_large_page), .page_start(page_start),
    .first_page(first_page), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .page_end(page_end), .bad_block(bad_block));

  int total = 0, bad = 0;
  int cyc = 0;
  bit wd_hit = 1'b0;
  logic [7:0] pg_in [PAGE];
  logic [7:0] pg_out [PAGE];
  logic [7:0] pg_orig [PAGE];
  bit bad_ref = 1'b0;
  int pe_cnt, pe_at_end, stall_bad, ready_low;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) wd_hit <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_at(input int i, input bit sw);
    if (sw && i == MARK) return pg_in[PAIR];
    if (sw && i == PAIR) return pg_in[MARK];
    return pg_in[i];
  endfunction

  task automatic fill_page(input logic [7:0] marker);
    for (int i = 0; i < PAGE; i++) pg_in[i] = 8'($urandom_range(255));
    pg_in[MARK] = marker;
    pg_in[PAIR] = marker ^ 8'h5A;
  endtask

  task automatic run_page(input bit il, input bit lp, input bit fp,
                          input int stall_pct, input int gap_pct, input bit flip);
    int ii, oi;
    bit pend_in, pend_out, prev_hold;
    logic [7:0] cap, prev_data;
    ii = 0; oi = 0; pend_in = 0; pend_out = 0; prev_hold = 0;
    cap = '0; prev_data = '0;
    pe_cnt = 0; pe_at_end = 0; stall_bad = 0; ready_low = 0;
    @(negedge clk);
    cfg_interleave = il; cfg_large_page = lp; first_page = fp; page_start = 1'b1;
    @(negedge clk);
    page_start = 1'b0;
    while (!wd_hit) begin
      @(negedge clk);
      if (pend_out) begin pg_out[oi] = cap; oi++; end
      if (pend_in) ii++;
      if (page_end) pe_cnt++;
      if (pend_out && oi == PAGE) pe_at_end = int'(page_end);
      if (prev_hold && (!out_valid || out_data != prev_data)) stall_bad++;
      if (oi == PAGE) break;
      if (flip && ii == 1000) begin
        cfg_interleave = ~il; cfg_large_page = ~lp;
      end
      in_valid = (ii < PAGE) && ($urandom_range(99) >= gap_pct);
      in_data  = (ii < PAGE) ? pg_in[ii] : 8'h00;
      out_ready = ($urandom_range(99) >= stall_pct);
      #1;
      pend_in  = in_valid && in_ready;
      pend_out = out_valid && out_ready;
      cap = out_data;
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
      if (stall_pct == 0 && !in_ready) ready_low++;
    end
    in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) begin
      @(negedge clk);
      if (page_end) pe_cnt++;
    end
    if (fp) bad_ref = (pg_in[MARK] != 8'hFF);
  endtask

  task automatic check_data(input bit sw, input string req);
    int errs, first;
    errs = 0; first = -1;
    for (int i = 0; i < PAGE; i++)
      if (pg_out[i] !== exp_at(i, sw)) begin
        errs++;
        if (first < 0) first = i;
      end
    if (first < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, int'(pg_out[first]), int'(exp_at(first, sw)));
  endtask

  task automatic check_side(input string tag);
    chk(pe_at_end == 1, "R8 page_end after last byte", pe_at_end, 1);
    chk(pe_cnt == 1, "R8 single page_end pulse", pe_cnt, 1);
    chk(stall_bad == 0, "R7 output held while stalled", stall_bad, 0);
    chk(bad_block == bad_ref, {"R9/R10 flag ", tag}, int'(bad_block), int'(bad_ref));
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!out_valid && !page_end && !bad_block && in_ready, "R1 reset state",
        {out_valid, page_end, bad_block, in_ready}, 4'b0001);

    // R2, R11: swap, no downstream stalls, good marker
    fill_page(8'hFF);
    run_page(1, 1, 1, 0, 20, 0);
    check_data(1, "R2 swap active");
    chk(ready_low == 0, "R11 in_ready with free output", ready_low, 0);
    check_side("good marker");

    // R6, R9: heavy stalls, bad marker on first page
    fill_page(8'h00);
    run_page(1, 1, 1, 60, 30, 0);
    check_data(1, "R6 backpressure swap");
    check_side("bad marker r9_");
    chk(bad_block == 1'b1, "R9 bad marker sets flag", int'(bad_block), 1);

    // R10: non-first page with good marker keeps flag
    fill_page(8'hFF);
    run_page(1, 1, 0, 30, 30, 0);
    check_data(1, "R2 swap second page");
    chk(bad_block == 1'b1, "R10 flag kept on later page", int'(bad_block), 1);

    // R3: pass-through modes
    fill_page(8'h12);
    run_page(0, 1, 0, 40, 10, 0);
    check_data(0, "R3 interleave off");
    fill_page(8'h34);
    run_page(1, 0, 0, 0, 0, 0);
    check_data(0, "R3 small page");
    chk(ready_low == 0, "R11 pass-through in_ready", ready_low, 0);

    // R4: config flips mid-page
    fill_page(8'h77);
    run_page(1, 1, 0, 25, 25, 1);
    check_data(1, "R4 flip off during swap page");
    fill_page(8'h88);
    run_page(0, 0, 0, 25, 25, 1);
    check_data(0, "R4 flip on during plain page");

    // R5: apply twice
    fill_page(8'hFF);
    for (int i = 0; i < PAGE; i++) pg_orig[i] = pg_in[i];
    run_page(1, 1, 1, 35, 35, 0);
    for (int i = 0; i < PAGE; i++) pg_in[i] = pg_out[i];
    run_page(1, 1, 0, 35, 35, 0);
    begin
      int errs;
      errs = 0;
      for (int i = 0; i < PAGE; i++) if (pg_out[i] !== pg_orig[i]) errs++;
      chk(errs == 0, "R5 double swap restores page", errs, 0);
    end

    // random pages, R6 under mixed modes
    for (int k = 0; k < 6; k++) begin
      bit il, lp, fp;
      il = 1'($urandom_range(1)); lp = 1'($urandom_range(1)); fp = 1'($urandom_range(1));
      fill_page(($urandom_range(3) == 0) ? 8'hFF : 8'($urandom_range(255)));
      run_page(il, lp, fp, $urandom_range(70), $urandom_range(50), 0);
      check_data(il && lp, "R6 random page");
      check_side("random");
    end

    chk(!wd_hit, "watchdog", int'(wd_hit), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule